// File: doc/BRIEF.md
# Translation Lookaside Cache with Pinned Entries

This block is a small fully associative cache of address translations. Each slot holds a page number, the frame number it maps to, a set of protection bits, a valid flag and a pinned flag. The lookup port compares a page number against every slot at once. In the same cycle it reports a hit, the frame number and the protection bits, so that a downstream permission checker can use them.

After a miss has been resolved elsewhere, the fill port installs the translation. A fill goes to a free slot when one exists. Otherwise it overwrites an unpinned slot chosen by a rotating pointer. A separate control pins or releases the slot that holds a given page, which keeps translations such as kernel mappings resident. A flush input, used on a context switch, drops every unpinned translation in one cycle and keeps the pinned ones. When every slot is pinned, a fill of a new page cannot proceed, and the block flags it.

Top module: `tlb_wired`

## Requirements
- R1: Lookup is combinational on the stored state. `lk_hit` is 1 exactly when a valid slot holds `lk_page`, and `lk_frame`/`lk_prot` then carry that slot's frame and protection. On a miss both are 0.
- R2: A fill whose page already sits in a valid slot rewrites that slot's frame and protection in place and creates no second copy. Its pinned flag becomes the old flag OR `fill_wire`.
- R3: A fill of an absent page goes to the lowest-index invalid slot when any slot is invalid, and the rotating pointer does not move.
- R4: When no slot is invalid, a fill of an absent page overwrites the first unpinned slot found scanning upward from the rotating pointer, wrapping at the top. The pointer then moves to that slot plus one, modulo the slot count. Pinned slots are never overwritten. The pointer is 0 after reset.
- R5: `full` is 1 exactly when every slot is pinned. A fill of an absent page at that time raises `fill_rej` in the same cycle and changes no stored state.
- R6: `flush` clears every unpinned slot in one cycle. Pinned slots keep their page, frame, protection and pinned flag, and the pointer is unchanged.
- R7: With `pin_en` high, `pin_op`=1 pins and `pin_op`=0 unpins the valid slot holding `pin_page`. An unpinned slot stays valid. If no slot holds the page, nothing changes. A pinned slot is always valid.
- R8: Only one action is taken per cycle, in this priority: flush, then fill, then pin. A lower-priority request in the same cycle is ignored, and `fill_rej` stays 0 for a fill that loses to a flush.
- R9: After reset every slot is invalid and unpinned, `lk_hit` and `full` are 0.
- R10: A fill of an absent page with `fill_wire`=1 installs the slot already pinned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_page | input | PAGE_W | Page number to translate |
| lk_hit | output | 1 | Translation found |
| lk_frame | output | FRAME_W | Frame number on a hit, else 0 |
| lk_prot | output | PROT_W | Protection bits on a hit, else 0 |
| fill_en | input | 1 | Install a translation |
| fill_page | input | PAGE_W | Page number to install |
| fill_frame | input | FRAME_W | Frame number to install |
| fill_prot | input | PROT_W | Protection bits to install |
| fill_wire | input | 1 | Install the slot pinned |
| fill_rej | output | 1 | Fill refused because every slot is pinned |
| pin_en | input | 1 | Pin or unpin request |
| pin_op | input | 1 | 1 pins, 0 unpins |
| pin_page | input | PAGE_W | Page whose slot is pinned or unpinned |
| flush | input | 1 | Drop all unpinned translations |
| full | output | 1 | Every slot pinned |

## Verification
The bench uses four slots and a 16-page space. After every operation it sweeps the lookup port over all 16 pages, so each stale copy, lost pinned mapping or wrong frame shows up as a mismatch on a specific page. The fill sequences are chosen to tell the cases apart. Filling into free slots checks lowest-index placement. Overflowing fills with zero, one and two pinned slots show whether the rotating pointer skips pinned slots and wraps. Refills of resident pages catch duplicate creation. Simultaneous flush, fill and pin requests reveal the priority order. A long deterministic fill stream, mixing pins, unpins and flushes, then compares every sweep against an arithmetic model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic {
    PIN_CLEAR = 1'b0,
    PIN_SET   = 1'b1
  } pin_kind_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FLUSH = 2'd1,
    OP_FILL  = 2'd2,
    OP_PIN   = 2'd3
  } op_sel_e;
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int ENTRIES = 16,
  parameter int PAGE_W  = 20
) (
  input  logic [ENTRIES-1:0]             slot_valid,
  input  logic [ENTRIES-1:0][PAGE_W-1:0] slot_page,
  input  logic [PAGE_W-1:0]              key,
  output logic [ENTRIES-1:0]             hits
);
  // one comparator per slot, all in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hits[g] = slot_valid[g] && (slot_page[g] == key);
  end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] slot_valid,
  input  logic [ENTRIES-1:0] slot_wired,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   victim,
  output logic               victim_ok,
  output logic               use_free
);
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic             rr_found;
  logic [IDX_W-1:0] rr_idx;

  // lowest-index invalid slot
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!free_found && !slot_valid[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  // first unpinned slot at or above the pointer, wrapping
  always_comb begin
    rr_found = 1'b0;
    rr_idx   = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (!rr_found && !slot_wired[(int'(rr_ptr) + k) % ENTRIES]) begin
        rr_found = 1'b1;
        rr_idx   = IDX_W'((int'(rr_ptr) + k) % ENTRIES);
      end
    end
  end

  always_comb begin
    use_free  = free_found;
    victim    = free_found ? free_idx : rr_idx;
    victim_ok = free_found || rr_found;
  end

  // R4
  victim_not_wired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_ok |-> !slot_wired[victim]);

  // R3
  free_slot_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_free |-> !slot_valid[victim]);
endmodule

// File: rtl/tlb_wired.sv
module tlb_wired #(
  parameter int ENTRIES = 16,
  parameter int PAGE_W  = 20,
  parameter int FRAME_W = 20,
  parameter int PROT_W  = 3,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  output logic [PROT_W-1:0]  lk_prot,
  input  logic               fill_en,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic [PROT_W-1:0]  fill_prot,
  input  logic               fill_wire,
  output logic               fill_rej,
  input  logic               pin_en,
  input  logic               pin_op,
  input  logic [PAGE_W-1:0]  pin_page,
  input  logic               flush,
  output logic               full
);
  import tlb_pkg::*;

  // stored state
  logic [ENTRIES-1:0]              valid_q, valid_d;
  logic [ENTRIES-1:0]              wired_q, wired_d;
  logic [IDX_W-1:0]                ptr_q, ptr_d;
  logic [ENTRIES-1:0][PAGE_W-1:0]  page_q;
  logic [ENTRIES-1:0][FRAME_W-1:0] frame_q;
  logic [ENTRIES-1:0][PROT_W-1:0]  prot_q;

  // match vectors
  logic [ENTRIES-1:0] lk_hits, fill_hits, pin_hits;
  logic               fill_hit;
  logic [IDX_W-1:0]   fill_idx;

  // replacement choice
  logic [IDX_W-1:0]   victim;
  logic               victim_ok, use_free;

  op_sel_e            op;
  pin_kind_e          pin_kind;
  logic               ctl_en, wr_en;
  logic [IDX_W-1:0]   wr_slot;

  tlb_cam_match #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W)) u_lk_match (
    .slot_valid(valid_q), .slot_page(page_q), .key(lk_page), .hits(lk_hits));

  tlb_cam_match #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W)) u_fill_match (
    .slot_valid(valid_q), .slot_page(page_q), .key(fill_page), .hits(fill_hits));

  tlb_cam_match #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W)) u_pin_match (
    .slot_valid(valid_q), .slot_page(page_q), .key(pin_page), .hits(pin_hits));

  tlb_victim_pick #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .slot_valid(valid_q), .slot_wired(wired_q),
    .rr_ptr(ptr_q), .victim(victim), .victim_ok(victim_ok), .use_free(use_free));

  // lookup read-out: OR of the matching slot's fields
  always_comb begin
    lk_hit   = |lk_hits;
    lk_frame = '0;
    lk_prot  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hits[i]) begin
        lk_frame = lk_frame | frame_q[i];
        lk_prot  = lk_prot  | prot_q[i];
      end
    end
  end

  // index of an already resident fill page
  always_comb begin
    fill_hit = |fill_hits;
    fill_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_hits[i]) fill_idx = fill_idx | IDX_W'(i);
    end
  end

  // request priority
  always_comb begin
    if (flush)       op = OP_FLUSH;
    else if (fill_en) op = OP_FILL;
    else if (pin_en)  op = OP_PIN;
    else              op = OP_IDLE;
  end

  assign pin_kind = pin_kind_e'(pin_op);
  assign full     = &wired_q;
  assign fill_rej = (op == OP_FILL) && !fill_hit && !victim_ok;
  assign wr_en    = (op == OP_FILL) && (fill_hit || victim_ok);
  assign wr_slot  = fill_hit ? fill_idx : victim;
  assign ctl_en   = (op != OP_IDLE);

  // next state of the control bits and pointer
  always_comb begin
    valid_d = valid_q;
    wired_d = wired_q;
    ptr_d   = ptr_q;
    unique case (op)
      OP_FLUSH: begin
        valid_d = valid_q & wired_q;
      end
      OP_FILL: begin
        if (fill_hit) begin
          wired_d[fill_idx] = wired_q[fill_idx] | fill_wire;
        end else if (victim_ok) begin
          valid_d[victim] = 1'b1;
          wired_d[victim] = fill_wire;
          if (!use_free) begin
            ptr_d = (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
          end
        end
      end
      OP_PIN: begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (pin_hits[i]) wired_d[i] = (pin_kind == PIN_SET);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      wired_q <= '0;
      ptr_q   <= '0;
    end else if (ctl_en) begin
      valid_q <= valid_d;
      wired_q <= wired_d;
      ptr_q   <= ptr_d;
    end
  end

  // payload storage, written only by an accepted fill
  always_ff @(posedge clk) begin
    if (wr_en) begin
      page_q[wr_slot]  <= fill_page;
      frame_q[wr_slot] <= fill_frame;
      prot_q[wr_slot]  <= fill_prot;
    end
  end

  // R1
  lk_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hits));

  // R2
  fill_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_hits));

  // R7
  wired_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wired_q & ~valid_q) == '0);

  // R6
  flush_keeps_wired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((valid_q == $past(wired_q)) && (wired_q == $past(wired_q))
               && (ptr_q == $past(ptr_q))));

  // R5
  reject_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_rej |=> ((valid_q == $past(valid_q)) && (wired_q == $past(wired_q))
                  && (ptr_q == $past(ptr_q))));

  // R5
  reject_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_rej |-> full);

  // R8
  flush_blocks_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fill_rej);
endmodule

// File: tb/tlb_wired_bench.sv
`timescale 1ns/1ps
module tlb_wired_bench;
  localparam int N  = 4;
  localparam int PW = 4;
  localparam int FW = 6;
  localparam int RW = 2;
  localparam int NP = 1 << PW;

  logic          clk, rst_n;
  logic [PW-1:0] lk_page, fill_page, pin_page;
  logic          lk_hit, fill_en, fill_wire, fill_rej, pin_en, pin_op, flush, full;
  logic [FW-1:0] lk_frame, fill_frame;
  logic [RW-1:0] lk_prot, fill_prot;

  tlb_wired #(.ENTRIES(N), .PAGE_W(PW), .FRAME_W(FW), .PROT_W(RW)) u_tlb_wired (
    .clk(clk), .rst_n(rst_n), .lk_page(lk_page), .lk_hit(lk_hit),
    .lk_frame(lk_frame), .lk_prot(lk_prot), .fill_en(fill_en),
    .fill_page(fill_page), .fill_frame(fill_frame), .fill_prot(fill_prot),
    .fill_wire(fill_wire), .fill_rej(fill_rej), .pin_en(pin_en),
    .pin_op(pin_op), .pin_page(pin_page), .flush(flush), .full(full));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks, fails;
  bit done;

  // reference model built from the requirements
  bit m_v[N];
  bit m_w[N];
  int m_pg[N];
  int m_fr[N];
  int m_pr[N];
  int m_ptr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_find(input int p);
    for (int i = 0; i < N; i++) if (m_v[i] && m_pg[i] == p) return i;
    return -1;
  endfunction

  function automatic bit m_full();
    for (int i = 0; i < N; i++) if (!m_w[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit m_rej(input bit fl, input bit fe, input int p);
    return !fl && fe && m_find(p) < 0 && m_full();
  endfunction

  task automatic m_apply(input bit fl, input bit fe, input int fp, input int ff,
                         input int fr, input bit fwr, input bit pe, input bit po,
                         input int pp);
    int s;
    if (fl) begin
      for (int i = 0; i < N; i++) if (!m_w[i]) m_v[i] = 1'b0;
    end else if (fe) begin
      s = m_find(fp);
      if (s >= 0) begin
        m_fr[s] = ff; m_pr[s] = fr; m_w[s] = m_w[s] | fwr;
      end else begin
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) s = i;
        if (s < 0) begin
          for (int k = N - 1; k >= 0; k--) if (!m_w[(m_ptr + k) % N]) s = (m_ptr + k) % N;
          if (s >= 0) m_ptr = (s + 1) % N;
        end
        if (s >= 0) begin
          m_v[s] = 1'b1; m_w[s] = fwr; m_pg[s] = fp; m_fr[s] = ff; m_pr[s] = fr;
        end
      end
    end else if (pe) begin
      s = m_find(pp);
      if (s >= 0) m_w[s] = po;
    end
  endtask

  task automatic op(input bit fl, input bit fe, input int fp, input int ff,
                    input int fr, input bit fwr, input bit pe, input bit po,
                    input int pp, input string req);
    @(negedge clk);
    flush = fl; fill_en = fe; fill_page = PW'(fp); fill_frame = FW'(ff);
    fill_prot = RW'(fr); fill_wire = fwr; pin_en = pe; pin_op = po; pin_page = PW'(pp);
    #0.5;
    chk(fill_rej == m_rej(fl, fe, fp), req, int'(fill_rej), int'(m_rej(fl, fe, fp)));
    @(posedge clk);
    m_apply(fl, fe, fp, ff, fr, fwr, pe, po, pp);
  endtask

  task automatic fill(input int p, input int f, input int r, input bit w, input string req);
    op(1'b0, 1'b1, p, f, r, w, 1'b0, 1'b0, 0, req);
  endtask

  task automatic pin(input int p, input bit on, input string req);
    op(1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b1, on, p, req);
  endtask

  // sweep the whole page space on the lookup port
  task automatic sweep(input string req);
    int s, ef, er;
    @(negedge clk);
    flush = 0; fill_en = 0; pin_en = 0;
    for (int p = 0; p < NP; p++) begin
      lk_page = PW'(p);
      #0.1;
      s  = m_find(p);
      ef = (s >= 0) ? m_fr[s] : 0;
      er = (s >= 0) ? m_pr[s] : 0;
      chk(lk_hit == (s >= 0), req, int'(lk_hit), int'(s >= 0));
      chk(int'(lk_frame) == ef, req, int'(lk_frame), ef);
      chk(int'(lk_prot) == er, req, int'(lk_prot), er);
    end
    chk(full == m_full(), "R5", int'(full), int'(m_full()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 0; flush = 0; fill_en = 0; pin_en = 0; pin_op = 0; fill_wire = 0;
    lk_page = 0; fill_page = 0; pin_page = 0; fill_frame = 0; fill_prot = 0;
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_w[i] = 0; m_pg[i] = 0; m_fr[i] = 0; m_pr[i] = 0;
    end
    m_ptr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    sweep("R9");                                // reset: all miss, not full
    for (int p = 1; p <= 4; p++) fill(p, 10 + p, p % 4, 1'b0, "R3");
    sweep("R3");
    fill(5, 20, 1, 1'b0, "R4"); sweep("R4");    // evicts slot 0
    fill(6, 21, 2, 1'b0, "R4"); sweep("R4");    // evicts slot 1
    fill(3, 33, 3, 1'b0, "R2"); sweep("R2");    // in place
    pin(5, 1'b1, "R7"); pin(4, 1'b1, "R7");
    pin(9, 1'b1, "R7"); sweep("R7");            // absent page: no effect
    for (int p = 7; p <= 10; p++) begin
      fill(p, 40 + p, p % 4, 1'b0, "R4"); sweep("R4");
    end
    op(1'b1, 1'b0, 0, 0, 0, 1'b0, 1'b0, 0, 0, "R6"); sweep("R6");
    fill(11, 50, 1, 1'b1, "R10"); fill(12, 51, 2, 1'b1, "R10");
    sweep("R10");
    fill(13, 52, 3, 1'b0, "R5"); sweep("R5");   // every slot pinned now
    fill(14, 53, 0, 1'b0, "R5"); sweep("R5");   // rejected
    fill(11, 60, 2, 1'b0, "R2"); sweep("R2");   // resident page still updates
    pin(12, 1'b0, "R7"); sweep("R7");
    op(1'b1, 1'b1, 14, 1, 1, 1'b0, 1'b1, 1'b0, 5, "R8"); sweep("R8");
    op(1'b0, 1'b1, 15, 2, 2, 1'b0, 1'b1, 1'b0, 4, "R8"); sweep("R8");
    // long deterministic stream
    for (int i = 0; i < 120; i++) begin
      if (i % 17 == 16)      op(1'b1, 1'b0, 0, 0, 0, 1'b0, 1'b0, 0, 0, "R6");
      else if (i % 5 == 4)   pin((i * 3) % NP, (i % 10) == 4, "R7");
      else                   fill((i * 7 + 3) % NP, (i * 5) % 64, i % 4, (i % 11) == 0, "R4");
      sweep("R1");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule